// File: doc/BRIEF.md
# Cascadable Pipelined Parity Checker

This block checks even parity on a bus of command and address bits that sits beside a registered buffer. A data word is captured on a rising clock edge. The parity bit that covers that word comes one clock later. The block lines the two up and produces two results three clocks after the word: a partial-parity output and an active-low error flag. When an error is reported, the flag stays low for a fixed number of cycles. A new error during that window starts the window again.

A wide bus can be split across two identical checkers. The lead checker folds its half of the data into the controller's parity bit. It presents the result early, two clocks after the data, on its partial-parity output. That output drives the parity input of the trailing checker. The trailing checker adds its own half and gives the final verdict at the usual three-clock latency. The lead checker's flag is not used and is held inactive.

When both chip-select inputs are high for a word, the partial-parity output keeps its previous value. Error detection still runs.

Top module: `cascade_parity_checker`

## Requirements
- R1: In standalone role, `err_n_o` goes low when the number of ones in the data word plus its parity bit is odd. It stays high when that count is even and no hold is running.
- R2: In standalone and lead roles, the parity bit for a word is taken from `par_i` on the rising edge one clock after the edge that captured the word.
- R3: In standalone role, `ppo_o` and `err_n_o` for a word change on the third rising edge after the edge that captured it. `ppo_o` is the XOR of the word's bits and its parity bit.
- R4: Once `err_n_o` goes low, it stays low for HOLD_CYCLES cycles (default 2). It then returns high unless a further error arrives.
- R5: An error that arrives while `err_n_o` is already held low restarts the full HOLD_CYCLES hold.
- R6: Reset is synchronous and active low. It forces `ppo_o` low and `err_n_o` high, ends any running hold, and clears the pipeline, so no stale word raises an error after release.
- R7: A word captured with `cs_a_n_i` and `cs_b_n_i` both high leaves `ppo_o` unchanged at that word's result slot. A word with only one of the two selects high updates `ppo_o` normally. The error flag is not gated by the selects.
- R8: Lead role is selected with `pair_mode_i`=1 and `upper_half_i`=0. In this role `ppo_o` gives the word's partial parity two rising edges after capture, and `err_n_o` is held high.
- R9: Trailing role is selected with `pair_mode_i`=1 and `upper_half_i`=1. In this role `par_i` is sampled on the third rising edge after the word's capture edge and combined with the word's own parity. `ppo_o` and `err_n_o` change on that same edge.
- R10: In a lead/trailing pair, the lead's `ppo_o` drives the trailing `par_i`. The trailing `err_n_o` then flags odd parity across both data halves plus the controller's parity bit, and the trailing `ppo_o` gives that combined XOR.
- R11: With `pair_mode_i`=0 the block runs in standalone role, whatever the value of `upper_half_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pair_mode_i | input | 1 | 0 = standalone, 1 = one of a cascaded pair |
| upper_half_i | input | 1 | In a pair: 0 = lead, 1 = trailing |
| cs_a_n_i | input | 1 | First chip select, active low |
| cs_b_n_i | input | 1 | Second chip select, active low |
| data_i | input | DATA_W | Data bits covered by parity |
| par_i | input | 1 | Controller parity bit, or upstream partial parity in trailing role |
| ppo_o | output | 1 | Partial-parity output |
| err_n_o | output | 1 | Parity error flag, active low, held after an error |

## Verification
Inputs are driven on the falling edge. A word driven there is captured on the next rising edge, called edge 0.

- In standalone and trailing roles, `ppo_o` and `err_n_o` are due after edge 3, so the bench reads them at the fourth falling edge after it drives the word.
- In lead role, `ppo_o` is due after edge 2 and is read one falling edge earlier.
- The parity bit is driven one falling edge after its word in standalone and lead roles, and three falling edges after it in trailing role.

The bench holds the expected results for each word in arrays indexed by the word number. It compares each array entry with the outputs read at that word's slot. Slots before the first word must show the reset values. The hold and its restart are replayed in the bench with a counter of its own.

// File: rtl/cpc_pkg.sv
// Package: shared types for the cascadable parity checker.
// Assumes: role pins are static while the block is out of reset.
package cpc_pkg;

    typedef enum logic [1:0] {
        ROLE_SINGLE = 2'd0,
        ROLE_LEAD   = 2'd1,
        ROLE_TRAIL  = 2'd2
    } role_e;

    // Map the two configuration pins to a role; the pair pin dominates.
    function automatic role_e role_decode(input logic pair_mode, input logic upper_half);
        if (!pair_mode) begin
            return ROLE_SINGLE;
        end else if (!upper_half) begin
            return ROLE_LEAD;
        end
        return ROLE_TRAIL;
    endfunction

endpackage

// File: rtl/cpc_xor_tree.sv
// Module: balanced XOR reduction, built by recursive halving.
// Does: drives odd_o high when bits_i holds an odd number of ones.
// Assumes: WIDTH >= 1; purely combinational.
module cpc_xor_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             odd_o
);

    generate
        if (WIDTH == 1) begin : g_leaf
            // A single bit is its own parity.
            assign odd_o = bits_i[0];
        end else begin : g_split
            localparam int LO_W = WIDTH / 2;
            localparam int HI_W = WIDTH - LO_W;
            logic lo_odd;
            logic hi_odd;

            cpc_xor_tree #(.WIDTH(LO_W)) u_lo (
                .bits_i (bits_i[LO_W-1:0]),
                .odd_o  (lo_odd)
            );

            cpc_xor_tree #(.WIDTH(HI_W)) u_hi (
                .bits_i (bits_i[WIDTH-1:LO_W]),
                .odd_o  (hi_odd)
            );

            // Join the two halves.
            assign odd_o = lo_odd ^ hi_odd;
        end
    endgenerate

endmodule

// File: rtl/cpc_align.sv
// Module: latency-alignment pipeline of the parity checker.
// Does: registers the data word, reduces it to one parity bit,
//   joins that bit with the parity input that arrives one clock later,
//   and registers the result so it appears three edges after the data.
//   It also provides an early, select-gated copy for the lead role.
// Assumes: synchronous active-low reset; role_i is static in operation.
module cpc_align
    import cpc_pkg::*;
#(
    parameter int DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  role_e             role_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_i,
    input  logic              gate_i,
    output logic              ppo_early_o,
    output logic              ppo_late_o,
    output logic              odd_o
);

    logic [DATA_W-1:0] data_q;
    logic              data_odd;
    logic              dpar2_q;
    logic              par_q;
    logic              sum_q;
    logic              dpar3_q;
    logic              gate1_q;
    logic              gate2_q;
    logic              gate3_q;

    cpc_xor_tree #(.WIDTH(DATA_W)) u_tree (
        .bits_i (data_q),
        .odd_o  (data_odd)
    );

    // Stage 1: capture the raw word and its select gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            gate1_q <= 1'b0;
        end else begin
            data_q  <= data_i;
            gate1_q <= gate_i;
        end
    end

    // Stage 2: keep the word's parity and capture the late parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpar2_q <= 1'b0;
            par_q   <= 1'b0;
            gate2_q <= 1'b0;
        end else begin
            dpar2_q <= data_odd;
            par_q   <= par_i;
            gate2_q <= gate1_q;
        end
    end

    // Stage 3: combined sum, forwarded data parity, and early gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q       <= 1'b0;
            dpar3_q     <= 1'b0;
            gate3_q     <= 1'b0;
            ppo_early_o <= 1'b0;
        end else begin
            sum_q   <= dpar2_q ^ par_q;
            dpar3_q <= dpar2_q;
            gate3_q <= gate2_q;
            if (!gate2_q) begin
                ppo_early_o <= dpar2_q ^ par_q;
            end
        end
    end

    // Result bit: trailing role folds in the upstream partial parity now.
    always_comb begin
        if (role_i == ROLE_TRAIL) begin
            odd_o = dpar3_q ^ par_i;
        end else begin
            odd_o = sum_q;
        end
    end

    // Stage 4: output partial parity, frozen for select-gated words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppo_late_o <= 1'b0;
        end else if (!gate3_q) begin
            ppo_late_o <= odd_o;
        end
    end

    // R7: a gated word must leave the late output unchanged.
    p_late_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate3_q |=> $stable(ppo_late_o))
        else $error("p_late_hold_r7 violated");

    // R7: a gated word must leave the early output unchanged.
    p_early_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate2_q |=> $stable(ppo_early_o))
        else $error("p_early_hold_r7 violated");

endmodule

// File: rtl/cpc_err_hold.sv
// Module: error-flag hold timer.
// Does: drives err_n_o low on a detected error and keeps it low for
//   HOLD_CYCLES cycles; a new error reloads the count.
// Assumes: fire_i is a one-cycle verdict per word; enable_i low
//   forces the flag inactive (lead role).
module cpc_err_hold #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic fire_i,
    output logic err_n_o
);

    localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Flag and remaining-hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_n_o <= 1'b1;
            cnt_q   <= '0;
        end else if (!enable_i) begin
            err_n_o <= 1'b1;
            cnt_q   <= '0;
        end else if (fire_i) begin
            err_n_o <= 1'b0;
            cnt_q   <= RELOAD;
        end else if (cnt_q != '0) begin
            err_n_o <= 1'b0;
            cnt_q   <= cnt_q - 1'b1;
        end else begin
            err_n_o <= 1'b1;
        end
    end

    // R4: an enabled error drives the flag low on the next edge.
    p_fire_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && fire_i) |=> !err_n_o)
        else $error("p_fire_low_r4 violated");

    // R4: with the hold used up and no new error, the flag releases.
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !fire_i && cnt_q == '0) |=> err_n_o)
        else $error("p_release_r4 violated");

    // R5: an error during a hold reloads the full count.
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && fire_i && !err_n_o) |=> (!err_n_o && cnt_q == RELOAD))
        else $error("p_restart_r5 violated");

endmodule

// File: rtl/cascade_parity_checker.sv
// Module: top of the cascadable pipelined parity checker.
// Does: decodes the role pins, runs the alignment pipeline and the
//   error-hold timer, and selects the partial-parity output for the role.
// Assumes: role pins are static out of reset; reset is synchronous,
//   active low; in a pair the lead ppo_o drives the trailing par_i.
module cascade_parity_checker
    import cpc_pkg::*;
#(
    parameter int DATA_W      = 22,
    parameter int HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_mode_i,
    input  logic              upper_half_i,
    input  logic              cs_a_n_i,
    input  logic              cs_b_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_i,
    output logic              ppo_o,
    output logic              err_n_o
);

    role_e role;
    logic  gate;
    logic  ppo_early;
    logic  ppo_late;
    logic  odd;
    logic  check_en;

    // Role and select-gate decode.
    always_comb begin
        role     = role_decode(pair_mode_i, upper_half_i);
        gate     = cs_a_n_i & cs_b_n_i;
        check_en = (role != ROLE_LEAD);
    end

    cpc_align #(.DATA_W(DATA_W)) u_align (
        .clk         (clk),
        .rst_n       (rst_n),
        .role_i      (role),
        .data_i      (data_i),
        .par_i       (par_i),
        .gate_i      (gate),
        .ppo_early_o (ppo_early),
        .ppo_late_o  (ppo_late),
        .odd_o       (odd)
    );

    cpc_err_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (check_en),
        .fire_i   (odd),
        .err_n_o  (err_n_o)
    );

    // Lead role presents the early result; other roles the aligned one.
    always_comb begin
        ppo_o = (role == ROLE_LEAD) ? ppo_early : ppo_late;
    end

    // R6: a reset edge leaves both outputs at their idle values.
    p_reset_idle_r6: assert property (@(posedge clk)
        !rst_n |=> (!ppo_o && err_n_o))
        else $error("p_reset_idle_r6 violated");

    // R8: the lead checker never reports an error.
    p_lead_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (role == ROLE_LEAD) |=> err_n_o)
        else $error("p_lead_quiet_r8 violated");

endmodule

// File: tb/cascade_parity_checker_tb_top.sv
module cascade_parity_checker_tb_top;

    localparam int W    = 8;
    localparam int HOLD = 2;
    localparam int MAXN = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pair = 1'b0;
    logic upper = 1'b0;
    logic cs_a_n = 1'b0;
    logic cs_b_n = 1'b0;
    logic [W-1:0] din = '0;
    logic pin = 1'b0;
    logic ppo;
    logic errn;

    logic [W-1:0] c_da = '0;
    logic [W-1:0] c_db = '0;
    logic c_par = 1'b0;
    logic lead_ppo, lead_errn, trail_ppo, trail_errn;

    int n_checks = 0;
    int n_err = 0;

    logic [W-1:0] da [0:MAXN-1];
    logic [W-1:0] db [0:MAXN-1];
    logic         pa [0:MAXN-1];
    logic         csa [0:MAXN-1];
    logic         csb [0:MAXN-1];
    logic         ppo_e [0:MAXN-1];
    logic         err_e [0:MAXN-1];
    string        ptag [0:MAXN-1];
    string        etag [0:MAXN-1];

    always #10 clk = ~clk;

    cascade_parity_checker #(.DATA_W(W), .HOLD_CYCLES(HOLD)) dut_i (
        .clk (clk), .rst_n (rst_n), .pair_mode_i (pair), .upper_half_i (upper),
        .cs_a_n_i (cs_a_n), .cs_b_n_i (cs_b_n), .data_i (din), .par_i (pin),
        .ppo_o (ppo), .err_n_o (errn)
    );

    cascade_parity_checker #(.DATA_W(W), .HOLD_CYCLES(HOLD)) casc_lead_i (
        .clk (clk), .rst_n (rst_n), .pair_mode_i (1'b1), .upper_half_i (1'b0),
        .cs_a_n_i (1'b0), .cs_b_n_i (1'b0), .data_i (c_da), .par_i (c_par),
        .ppo_o (lead_ppo), .err_n_o (lead_errn)
    );

    cascade_parity_checker #(.DATA_W(W), .HOLD_CYCLES(HOLD)) casc_trail_i (
        .clk (clk), .rst_n (rst_n), .pair_mode_i (1'b1), .upper_half_i (1'b1),
        .cs_a_n_i (1'b0), .cs_b_n_i (1'b0), .data_i (c_db), .par_i (lead_ppo),
        .ppo_o (trail_ppo), .err_n_o (trail_errn)
    );

    task automatic check(input logic got, input logic exp, input string tag, input string what);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    // Build stimulus: variant 0 starts with an exhaustive data/parity sweep.
    task automatic fill(input int n, input int variant);
        for (int t = 0; t < n; t++) begin
            logic bad;
            bad = (t % 9 == 0) || (t % 23 == 0) || (t % 23 == 2) ||
                  (t % 31 == 5) || (t % 31 == 6);
            db[t] = (variant == 2) ? W'(t * 11 + 3) : '0;
            if (variant == 0 && t < 512) begin
                da[t] = W'(t);
                pa[t] = t[8];
                csa[t] = 1'b0;
                csb[t] = 1'b0;
            end else begin
                da[t] = W'(t * 37 + variant * 13);
                pa[t] = (^da[t]) ^ (^db[t]) ^ bad;
                csa[t] = (t % 17 == 3) || (t % 17 == 4) || (t % 17 == 8);
                csb[t] = (t % 17 == 3) || (t % 17 == 4) || (t % 17 == 9);
            end
        end
    endtask

    // Expected results per word, from the requirements.
    task automatic build_expect(input int n);
        logic prev;
        int cnt;
        prev = 1'b0;
        cnt = 0;
        for (int w = 0; w < n; w++) begin
            logic odd, gated;
            odd = (^da[w]) ^ (^db[w]) ^ pa[w];
            gated = csa[w] & csb[w];
            ppo_e[w] = gated ? prev : odd;
            prev = ppo_e[w];
            ptag[w] = gated ? "R7" : "R3";
            if (odd) begin
                etag[w] = (cnt > 0) ? "R5" : "R1/R2";
                cnt = HOLD - 1;
                err_e[w] = 1'b0;
            end else if (cnt > 0) begin
                cnt--;
                err_e[w] = 1'b0;
                etag[w] = "R4";
            end else begin
                err_e[w] = 1'b1;
                etag[w] = "R1/R2";
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = '0; pin = 1'b0; cs_a_n = 1'b0; cs_b_n = 1'b0;
        c_da = '0; c_db = '0; c_par = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode 0: aligned outputs of dut_i; 1: dut_i lead role; 2: cascade pair.
    task automatic run_stream(input int n, input int lag, input int mode, input string tag);
        for (int c = 0; c < n + 5; c++) begin
            int w4, w3, k;
            @(negedge clk);
            w4 = c - 4;
            w3 = c - 3;
            k = c - lag;
            if (mode == 0) begin
                if (w4 < 0) begin
                    check(ppo, 1'b0, "R6", "ppo before first word");
                    check(errn, 1'b1, "R6", "flag before first word");
                end else if (w4 < n) begin
                    check(ppo, ppo_e[w4], (tag == "") ? ptag[w4] : tag, $sformatf("ppo word %0d", w4));
                    check(errn, err_e[w4], (tag == "") ? etag[w4] : tag, $sformatf("flag word %0d", w4));
                end
            end else if (mode == 1) begin
                if (w3 < 0) check(ppo, 1'b0, "R6", "lead ppo before first word");
                else if (w3 < n) check(ppo, ppo_e[w3], "R8", $sformatf("lead early ppo word %0d", w3));
                check(errn, 1'b1, "R8", "lead flag held high");
            end else begin
                if (w3 < 0) check(lead_ppo, 1'b0, "R6", "pair lead ppo before first word");
                else if (w3 < n) check(lead_ppo, (^da[w3]) ^ pa[w3], "R10", $sformatf("pair lead ppo word %0d", w3));
                check(lead_errn, 1'b1, "R8", "pair lead flag");
                if (w4 < 0) begin
                    check(trail_ppo, 1'b0, "R6", "pair trail ppo before first word");
                    check(trail_errn, 1'b1, "R6", "pair trail flag before first word");
                end else if (w4 < n) begin
                    check(trail_ppo, ppo_e[w4], "R10", $sformatf("pair trail ppo word %0d", w4));
                    check(trail_errn, err_e[w4], "R10", $sformatf("pair trail flag word %0d", w4));
                end
            end
            if (mode == 2) begin
                c_da = (c < n) ? da[c] : '0;
                c_db = (c < n) ? db[c] : '0;
                c_par = (k >= 0 && k < n) ? pa[k] : 1'b0;
            end else begin
                din = (c < n) ? da[c] : '0;
                cs_a_n = (c < n) ? csa[c] : 1'b0;
                cs_b_n = (c < n) ? csb[c] : 1'b0;
                pin = (k >= 0 && k < n) ? pa[k] : 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        // Standalone role, exhaustive sweep, then holds, restarts and gating (R1..R7).
        pair = 1'b0; upper = 1'b0;
        do_reset();
        fill(1024, 0);
        build_expect(1024);
        run_stream(1024, 1, 0, "");

        // R11: upper pin ignored when not paired.
        pair = 1'b0; upper = 1'b1;
        do_reset();
        fill(64, 1);
        build_expect(64);
        run_stream(64, 1, 0, "R11");

        // R9: trailing role, parity input sampled on the third edge.
        pair = 1'b1; upper = 1'b1;
        do_reset();
        fill(256, 1);
        build_expect(256);
        run_stream(256, 3, 0, "R9");

        // R8: lead role, early partial parity, flag quiet.
        pair = 1'b1; upper = 1'b0;
        do_reset();
        fill(256, 1);
        build_expect(256);
        run_stream(256, 1, 1, "");

        // R10: cascaded pair over split data.
        do_reset();
        fill(256, 2);
        for (int t = 0; t < 256; t++) begin
            csa[t] = 1'b0;
            csb[t] = 1'b0;
        end
        build_expect(256);
        run_stream(256, 1, 2, "");

        // R6: reset asserted while the flag is being held low.
        pair = 1'b0; upper = 1'b0;
        do_reset();
        @(negedge clk); din = 8'h01; pin = 1'b0;
        @(negedge clk); din = '0; pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(errn, 1'b0, "R1", "flag for odd word before reset");
        check(ppo, 1'b1, "R3", "ppo for odd word before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check(errn, 1'b1, "R6", "flag after reset during hold");
        check(ppo, 1'b0, "R6", "ppo after reset during hold");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(errn, 1'b1, "R6", "flag stays high after release");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule